// File: doc/BRIEF.md
# Sparse Parallel-Prefix Binary Adder

This block adds two unsigned WIDTH-bit operands and a carry-in and returns the WIDTH-bit sum and the carry-out. It is purely combinational: there are no registers, no clock and no reset, so the result follows the operands in the same evaluation. The block is meant to sit inside a wider datapath, for example an address generator or an accumulator, where the surrounding logic does any registering.

The carry network is a thinned prefix tree. In its first stage, each bit produces a propagate term (operand bits differ) and a generate term (both operand bits set). The tree then runs a dense doubling-distance combine over the odd bit positions only. A single closing row joins each even position with the finished odd group just below it. No node drives more than two loads. The tree is log2(WIDTH)+1 levels deep. A final stage folds in the carry-in and forms each sum bit as its propagate term XOR its incoming carry.

WIDTH is a parameter and must be a power of two no smaller than 4. The default is 16.

Top module: `hc_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum_out} equals the WIDTH+1-bit arithmetic value a_in + b_in + carry_in.
- R2: Raising carry_in with the operands held increases the WIDTH+1-bit result {carry_out, sum_out} by exactly one.
- R3: When every bit position propagates (a_in XOR b_in is all ones), carry_in travels the whole word: carry_out equals carry_in and sum_out is all ones when carry_in is 0 and all zeros when carry_in is 1.
- R4: When the operands share no set bit (a_in AND b_in is zero) and carry_in is 0, carry_out is 0 and sum_out equals a_in OR b_in.
- R5: All-ones plus all-ones gives carry_out 1 and sum_out equal to all ones with bit 0 replaced by carry_in.
- R6: The block holds no state: the outputs depend only on the present inputs, and the same inputs give the same outputs in any order of application.
- R7: The arithmetic of R1 holds for every legal WIDTH; it is checked exhaustively at WIDTH 4 and WIDTH 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First addend |
| b_in | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Low WIDTH bits of the sum |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench covers every operand pair and carry-in at widths 4 and 8. This reaches the skipped even positions that only the closing row repairs. A missing or misrouted cell in that row gives wrong sums on even bits whenever a carry arrives from below. The full-length propagate cases (all ones plus one, and complementary operands with a carry-in) catch a tree that stops one doubling short: its carry would die partway up the word. Disjoint operands and all-ones plus all-ones catch a carry-in merged as a generate instead of gated by the group propagate. That fault would show up as a spurious or missing carry-out.

// File: rtl/hc_adder_pkg.sv
package hc_adder_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Prefix combine: upper span "hi" absorbs lower span "lo".
  function automatic gp_t gp_combine(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/hc_pg_stage.sv
module hc_pg_stage
  import hc_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output gp_t  [WIDTH-1:0] pg_out
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pg_out[i].g = a_in[i] & b_in[i];
    assign pg_out[i].p = a_in[i] ^ b_in[i];
  end

endmodule

// File: rtl/hc_sparse_tree.sv
module hc_sparse_tree
  import hc_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  gp_t [WIDTH-1:0] pg_in,
  output gp_t [WIDTH-1:0] grp_out
);

  localparam int LEVELS = $clog2(WIDTH);

  // node[l] holds the spans after l odd-only levels.
  gp_t [LEVELS:0][WIDTH-1:0] node;

  assign node[0] = pg_in;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int DIST = 1 << l;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if ((i % 2 == 1) && (i >= DIST)) begin : g_cell
        assign node[l+1][i] = gp_combine(node[l][i], node[l][(i >= DIST) ? i - DIST : 0]);
      end else begin : g_pass
        assign node[l+1][i] = node[l][i];
      end
    end
  end

  // Closing row: each even position joins the odd group right below it.
  for (genvar i = 0; i < WIDTH; i++) begin : g_fill
    if ((i % 2 == 0) && (i >= 2)) begin : g_cell
      assign grp_out[i] = gp_combine(node[LEVELS][i], node[LEVELS][(i >= 1) ? i - 1 : 0]);
    end else begin : g_pass
      assign grp_out[i] = node[LEVELS][i];
    end
  end

endmodule

// File: rtl/hc_sum_stage.sv
module hc_sum_stage
  import hc_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] prop_in,
  input  gp_t  [WIDTH-1:0] grp_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  logic [WIDTH:0] carry;

  assign carry[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign carry[i+1]  = grp_in[i].g | (grp_in[i].p & carry_in);
    assign sum_out[i]  = prop_in[i] ^ carry[i];
  end

  assign carry_out = carry[WIDTH];

endmodule

// File: rtl/hc_adder.sv
module hc_adder
  import hc_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  if ((WIDTH < 4) || ((WIDTH & (WIDTH - 1)) != 0)) begin : g_bad_width
    $error("hc_adder: WIDTH must be a power of two of at least 4");
  end

  gp_t  [WIDTH-1:0] pg;
  gp_t  [WIDTH-1:0] grp;
  logic [WIDTH-1:0] prop;

  hc_pg_stage #(.WIDTH(WIDTH)) u_pg (
    .a_in   (a_in),
    .b_in   (b_in),
    .pg_out (pg)
  );

  hc_sparse_tree #(.WIDTH(WIDTH)) u_tree (
    .pg_in   (pg),
    .grp_out (grp)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_prop
    assign prop[i] = pg[i].p;
  end

  hc_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .prop_in   (prop),
    .grp_in    (grp),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
  );

endmodule

// File: rtl/hc_adder_chk.sv
module hc_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out
);

  logic [WIDTH:0] exact;
  assign exact = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    AST_SUM_EXACT: assert ({carry_out, sum_out} == exact) else $error("sum mismatch"); // R1
    if ((a_in ^ b_in) == {WIDTH{1'b1}}) begin
      AST_FULL_PROPAGATE: assert ((carry_out == carry_in) && (sum_out == {WIDTH{~carry_in}})) else $error("propagate chain broken"); // R3
    end
    if (((a_in & b_in) == '0) && !carry_in) begin
      AST_NO_SPURIOUS_CARRY: assert (!carry_out && (sum_out == (a_in | b_in))) else $error("spurious carry"); // R4
    end
    if ((a_in == {WIDTH{1'b1}}) && (b_in == {WIDTH{1'b1}})) begin
      AST_DOUBLE_ONES: assert (carry_out && (sum_out == {{(WIDTH-1){1'b1}}, carry_in})) else $error("all-ones sum wrong"); // R5
    end
  end

endmodule

bind hc_adder hc_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in      (a_in),
  .b_in      (b_in),
  .carry_in  (carry_in),
  .sum_out   (sum_out),
  .carry_out (carry_out)
);

// File: tb/test_hc_adder.sv
module test_hc_adder;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int TIMEOUT_CYCLES = 190000;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] a, b, s;
  logic         ci, co;
  logic [3:0]   a4, b4, s4;
  logic         ci4, co4;
  logic [7:0]   a8, b8, s8;
  logic         ci8, co8;

  hc_adder #(.WIDTH(W)) i_hc_adder (
    .a_in(a), .b_in(b), .carry_in(ci), .sum_out(s), .carry_out(co));
  hc_adder #(.WIDTH(4)) i_hc_adder_w4 (
    .a_in(a4), .b_in(b4), .carry_in(ci4), .sum_out(s4), .carry_out(co4));
  hc_adder #(.WIDTH(8)) i_hc_adder_w8 (
    .a_in(a8), .b_in(b8), .carry_in(ci8), .sum_out(s8), .carry_out(co8));

  task automatic chk16(input logic [W:0] exp, input string req);
    checks++;
    if ({co, s} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h ci=%b got=%h exp=%h", req, a, b, ci, {co, s}, exp);
    end
  endtask

  task automatic apply16(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string req);
    a = x; b = y; ci = c;
    #(CLK_PERIOD / 2);
    chk16({1'b0, x} + {1'b0, y} + {{W{1'b0}}, c}, req);
    #(CLK_PERIOD / 2);
  endtask

  initial begin
    logic [W:0] r0, r1;
    a = '0; b = '0; ci = 0;
    a4 = '0; b4 = '0; ci4 = 0;
    a8 = '0; b8 = '0; ci8 = 0;
    #(CLK_PERIOD / 2);
    // R1 initial state: all zero inputs give zero
    chk16('0, "R1 zero");
    #(CLK_PERIOD / 2);

    apply16('1, '1, 0, "R5 ones+ones");
    chk16({1'b1, {(W-1){1'b1}}, 1'b0}, "R5 ones+ones ci0");
    apply16('1, '1, 1, "R5 ones+ones ci1");
    apply16('1, '0, 1, "R3 ffff+0+1");
    chk16({1'b1, {W{1'b0}}}, "R3 ripple to top");
    apply16('1, 16'h0001, 0, "R3 ffff+1");
    apply16(16'hAAAA, 16'h5555, 1, "R3 alternating ci1");
    chk16({1'b1, {W{1'b0}}}, "R3 alternating carry-through");
    apply16(16'hAAAA, 16'h5555, 0, "R4 alternating ci0");
    chk16({1'b0, {W{1'b1}}}, "R4 disjoint no carry");
    apply16(16'hAAAA, 16'hAAAA, 0, "R1 alternating doubled");
    apply16(16'h5555, 16'h5555, 1, "R1 alternating doubled ci");
    apply16(16'h0F0F, 16'h3030, 0, "R4 disjoint mix");
    apply16(16'h8000, 16'h8000, 0, "R1 top carry");

    // R2: carry-in adds exactly one
    for (int k = 0; k < 200; k++) begin
      a = W'($urandom); b = W'($urandom);
      ci = 0; #(CLK_PERIOD / 2); r0 = {co, s}; #(CLK_PERIOD / 2);
      ci = 1; #(CLK_PERIOD / 2); r1 = {co, s};
      checks++;
      if (r1 !== r0 + 1'b1) begin
        errors++;
        $display("FAIL R2 a=%h b=%h got=%h exp=%h", a, b, r1, r0 + 1'b1);
      end
      #(CLK_PERIOD / 2);
    end

    // R6: same inputs after other traffic give the same result
    apply16(16'h1234, 16'hFEDC, 1, "R6 first");
    r0 = {co, s};
    apply16(16'hFFFF, 16'h0001, 0, "R6 other");
    a = 16'h1234; b = 16'hFEDC; ci = 1; #(CLK_PERIOD / 2);
    checks++;
    if ({co, s} !== r0) begin
      errors++;
      $display("FAIL R6 got=%h exp=%h", {co, s}, r0);
    end
    #(CLK_PERIOD / 2);

    // R1 random sweep
    for (int k = 0; k < 10000; k++)
      apply16(W'($urandom), W'($urandom), 1'($urandom), "R1 random");

    // R7 exhaustive at width 4
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++) begin
          a4 = 4'(x); b4 = 4'(y); ci4 = 1'(c);
          #1;
          checks++;
          if ({co4, s4} !== 5'(x + y + c)) begin
            errors++;
            $display("FAIL R7 w4 a=%h b=%h ci=%0d got=%h exp=%h", x, y, c, {co4, s4}, 5'(x + y + c));
          end
        end

    // R7 exhaustive at width 8
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++) begin
          a8 = 8'(x); b8 = 8'(y); ci8 = 1'(c);
          #1;
          checks++;
          if ({co8, s8} !== 9'(x + y + c)) begin
            errors++;
            $display("FAIL R7 w8 a=%h b=%h ci=%0d got=%h exp=%h", x, y, c, {co8, s8}, 9'(x + y + c));
          end
        end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * TIMEOUT_CYCLES);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule